// File: doc/BRIEF.md
# Power Control and Address Strobe Gating

This block sits on the special-function-register bus of a small 8-bit microcontroller core. It holds the power configuration register and sends idle and power-down requests to the clock controller. The core's firmware sets a request bit by writing the register. The hardware clears both requests when an interrupt is pending, which wakes the core.

The same register holds three more things. It has a select bit that decides what two bit positions of the serial-control register reach. With the select bit at 0 they reach the serial mode bits, and with it at 1 they reach the framing-error and overrun flags. The register also has a baud-doubling flag and a pad pull-up control, and the block exports both. A separate auxiliary register holds a strobe-disable bit. With that bit set, the address-latch strobe is driven only during external bus cycles. At all other times the pin is released so it floats weakly high.

All read data is combinational from the address. All register updates take effect at the clock edge that samples the write.

Top module: `pwr_strobe_ctl`

## Requirements
- R1: After a synchronous active-low reset, the power register (address 0x87) and the auxiliary register (address 0x8E) read 0x00. idle_req and pd_req are 0, the serial mode bits and both error flags are 0, and the strobe follows strobe_raw with drive enabled.
- R2: A write to 0x87 updates the register at the edge that samples it, so its outputs change one cycle after the write. Bit 0 set with bit 1 clear raises idle_req. Bit 1 set raises pd_req.
- R3: When bits 1 and 0 are both 1, pd_req is 1 and idle_req is 0.
- R4: While irq_pending is 1, bits 1:0 of the power register are cleared at the next edge. This happens even if a write in the same cycle sets them, and the other bits of that write still take effect.
- R5: Bit 7 (baud_dbl), bit 3 (pullup_ctl) and bit 2 (a general software flag) are stored as written and read back. Bits 7 and 3 are driven on their output ports.
- R6: Bits 5 and 4 of the power register always read 0, and writing them has no effect.
- R7: With power bit 6 at 0, read and write accesses to bits 7:6 of the serial-control register (0x98) reach the mode bits. Bit 7 maps to ser_mode[1] and bit 6 maps to ser_mode[0]. The error flags are not touched by these writes.
- R8: With power bit 6 at 1, bits 7:6 of 0x98 reach ser_fe and ser_ovr, and the mode bits keep their value. A pulse on uart_fe_set or uart_ovr_set sets its flag, and this wins over a same-cycle software write.
- R9: While auxiliary bit 0 is 0, strobe_out equals strobe_raw and strobe_drive_en is 1 in every cycle.
- R10: While auxiliary bit 0 is 1, strobe_out equals strobe_raw with drive enabled only while cyc_movx, cyc_movc or cyc_fetch is 1. Otherwise strobe_out is 1 and strobe_drive_en is 0.
- R11: Auxiliary bits 7:1 read 0. Bits 5:0 of 0x98, and any address the block does not own, read 0x00. Writes to addresses the block does not own change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Register bus address for reads and writes |
| sfr_wr | input | 1 | Write strobe for the addressed register |
| sfr_wdata | input | 8 | Write data |
| sfr_rd_data | output | 8 | Read data for the current address, 0 when not owned |
| irq_pending | input | 1 | Interrupt pending; clears the power requests |
| uart_fe_set | input | 1 | Pulse from the serial port on a framing error |
| uart_ovr_set | input | 1 | Pulse from the serial port on an overrun |
| ser_mode | output | 2 | Serial mode bits for the serial port |
| ser_fe | output | 1 | Framing-error flag |
| ser_ovr | output | 1 | Overrun flag |
| baud_dbl | output | 1 | Baud-doubling control to the serial port |
| pullup_ctl | output | 1 | Pad pull-up control |
| idle_req | output | 1 | Idle request to the clock controller |
| pd_req | output | 1 | Power-down request to the clock controller |
| strobe_raw | input | 1 | Address-latch strobe from the core timing |
| cyc_movx | input | 1 | Current cycle is an external data move |
| cyc_movc | input | 1 | Current cycle is a code-memory read |
| cyc_fetch | input | 1 | Current cycle is an external instruction fetch |
| strobe_out | output | 1 | Address-latch strobe to the pin |
| strobe_drive_en | output | 1 | Pin drive enable; 0 leaves the pin weakly high |

## Verification
Two cases are hard to reach from the ports. The first is a same-edge collision, where a write that sets the request bits meets a pending interrupt. The second is a hardware flag pulse in the same cycle as a software write to that flag under the error-flag select. The stimulus makes both events share one clock cycle on purpose. A behavioural model then checks that the hardware side wins while the other written bits still land. The select bit is toggled between serial-control writes, so that each mapping is shown to leave the other pair of bits untouched.

// File: rtl/pwr_strobe_pkg.sv
// Package: shared bus widths, register addresses and bit positions for the
// power-control and strobe-gating block. Assumes an 8-bit register bus.
package pwr_strobe_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam logic [ADDR_W-1:0] PWR_ADDR  = 8'h87;
    localparam logic [ADDR_W-1:0] AUX_ADDR  = 8'h8E;
    localparam logic [ADDR_W-1:0] SCTL_ADDR = 8'h98;
    // Bit positions inside the power configuration register
    localparam int BIT_IDLE  = 0;
    localparam int BIT_PD    = 1;
    localparam int BIT_GPF   = 2;
    localparam int BIT_PULL  = 3;
    localparam int BIT_SEL   = 6;
    localparam int BIT_BAUD  = 7;
    // Implemented (writable) bits; 5 and 4 are reserved
    localparam logic [DATA_W-1:0] PWR_WMASK = 8'hCF;
    // Serial-control bits steered by the select bit
    localparam int SCTL_LO   = 6;
    localparam int N_STEER   = 2;
    // Number of bus-cycle kinds that keep the strobe alive
    localparam int N_EXT_CYC = 3;
endpackage

// File: rtl/pwr_cfg_reg.sv
// Power configuration register. It stores the implemented bits, drops writes
// to the reserved bits, and clears the two mode-request bits while an
// interrupt is pending, with priority over a same-cycle write. Power-down
// outranks idle on the request outputs.
// Assumes: the write strobe is already qualified by the address.
module pwr_cfg_reg
    import pwr_strobe_pkg::*;
#(
    parameter int W = DATA_W,
    parameter logic [W-1:0] WMASK = PWR_WMASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    input  logic         irq_pending,
    output logic [W-1:0] cfg,
    output logic         idle_req,
    output logic         pd_req
);
    logic [W-1:0] cfg_q;
    logic [W-1:0] cfg_d;

    // Next value: masked write, then the hardware clear of the request bits
    always_comb begin
        cfg_d = cfg_q;
        if (wr_hit) begin
            cfg_d = wdata & WMASK;
        end
        if (irq_pending) begin
            cfg_d[BIT_IDLE] = 1'b0;
            cfg_d[BIT_PD]   = 1'b0;
        end
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Request outputs; power-down suppresses idle
    always_comb begin
        cfg      = cfg_q;
        pd_req   = cfg_q[BIT_PD];
        idle_req = cfg_q[BIT_IDLE] & ~cfg_q[BIT_PD];
    end
endmodule

// File: rtl/sctl_steer.sv
// Serial-control bit steering. It holds the serial mode bits and the two
// error flags that share the same bit positions of the serial-control
// register. The select input decides which pair a bus access reaches.
// Hardware error pulses set their flag and win over a software write.
// Assumes: the write strobe is already qualified by the address.
module sctl_steer
    import pwr_strobe_pkg::*;
#(
    parameter int N = N_STEER
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [N-1:0] wbits,
    input  logic         flag_sel,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] mode_q,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] rd_bits
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        // Mode bit: written only while the mode pair is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[i] <= 1'b0;
            end else if (wr_hit && !flag_sel) begin
                mode_q[i] <= wbits[i];
            end
        end

        // Error flag: hardware set wins, else a selected software write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (hw_set[i]) begin
                flag_q[i] <= 1'b1;
            end else if (wr_hit && flag_sel) begin
                flag_q[i] <= wbits[i];
            end
        end

        // Read view of the slot follows the select bit
        always_comb begin
            rd_bits[i] = flag_sel ? flag_q[i] : mode_q[i];
        end
    end
endmodule

// File: rtl/strobe_gate.sv
// Auxiliary register and address-strobe gate. While the disable bit is
// clear, the raw strobe passes every cycle. While it is set, the strobe
// passes only during the listed external cycle kinds; otherwise the pin
// drive is released and the output rests high.
// Assumes: the write strobe is already qualified by the address.
module strobe_gate
    import pwr_strobe_pkg::*;
#(
    parameter int N_CYC = N_EXT_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             wbit,
    input  logic             strobe_raw,
    input  logic [N_CYC-1:0] ext_cyc,
    output logic             dis_q,
    output logic             strobe_out,
    output logic             drive_en
);
    // Disable bit storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b0;
        end else if (wr_hit) begin
            dis_q <= wbit;
        end
    end

    // Gate: drive when enabled or during an external cycle
    always_comb begin
        drive_en   = !dis_q || (|ext_cyc);
        strobe_out = drive_en ? strobe_raw : 1'b1;
    end
endmodule

// File: rtl/pwr_strobe_ctl.sv
// Top: power configuration, serial-control steering and strobe gating on
// one register bus. Read data is combinational from the address; unowned
// addresses and unimplemented bits read zero.
// Assumes: one write per cycle; the read mux is merged with other
// peripherals outside this block.
module pwr_strobe_ctl
    import pwr_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rd_data,
    input  logic              irq_pending,
    input  logic              uart_fe_set,
    input  logic              uart_ovr_set,
    output logic [1:0]        ser_mode,
    output logic              ser_fe,
    output logic              ser_ovr,
    output logic              baud_dbl,
    output logic              pullup_ctl,
    output logic              idle_req,
    output logic              pd_req,
    input  logic              strobe_raw,
    input  logic              cyc_movx,
    input  logic              cyc_movc,
    input  logic              cyc_fetch,
    output logic              strobe_out,
    output logic              strobe_drive_en
);
    localparam int SCTL_HI = SCTL_LO + N_STEER - 1;

    logic              pwr_wr, aux_wr, sctl_wr;
    logic [DATA_W-1:0] cfg;
    logic              flag_sel;
    logic              strobe_dis;
    logic [N_STEER-1:0] mode_q, flag_q, steer_rd;

    // Address decode for writes
    always_comb begin
        pwr_wr  = sfr_wr && (sfr_addr == PWR_ADDR);
        aux_wr  = sfr_wr && (sfr_addr == AUX_ADDR);
        sctl_wr = sfr_wr && (sfr_addr == SCTL_ADDR);
    end

    pwr_cfg_reg #(.W(DATA_W), .WMASK(PWR_WMASK)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (pwr_wr),
        .wdata       (sfr_wdata),
        .irq_pending (irq_pending),
        .cfg         (cfg),
        .idle_req    (idle_req),
        .pd_req      (pd_req)
    );

    assign flag_sel = cfg[BIT_SEL];

    sctl_steer #(.N(N_STEER)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (sctl_wr),
        .wbits    (sfr_wdata[SCTL_HI:SCTL_LO]),
        .flag_sel (flag_sel),
        .hw_set   ({uart_fe_set, uart_ovr_set}),
        .mode_q   (mode_q),
        .flag_q   (flag_q),
        .rd_bits  (steer_rd)
    );

    strobe_gate #(.N_CYC(N_EXT_CYC)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (aux_wr),
        .wbit       (sfr_wdata[0]),
        .strobe_raw (strobe_raw),
        .ext_cyc    ({cyc_fetch, cyc_movc, cyc_movx}),
        .dis_q      (strobe_dis),
        .strobe_out (strobe_out),
        .drive_en   (strobe_drive_en)
    );

    // Exported controls
    always_comb begin
        ser_mode   = mode_q;
        ser_fe     = flag_q[1];
        ser_ovr    = flag_q[0];
        baud_dbl   = cfg[BIT_BAUD];
        pullup_ctl = cfg[BIT_PULL];
    end

    // Read multiplexer
    always_comb begin
        sfr_rd_data = '0;
        case (sfr_addr)
            PWR_ADDR:  sfr_rd_data = cfg;
            AUX_ADDR:  sfr_rd_data[0] = strobe_dis;
            SCTL_ADDR: sfr_rd_data[SCTL_HI:SCTL_LO] = steer_rd;
            default:   sfr_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pwr_strobe_chk.sv
// Checker for pwr_strobe_ctl, attached with bind. It relates the bus
// inputs, the internal register outputs and the top-level ports over time.
module pwr_strobe_chk
    import pwr_strobe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sfr_wr,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic [1:0]        wr_req_bits,
    input logic [DATA_W-1:0] sfr_rd_data,
    input logic              irq_pending,
    input logic              idle_req,
    input logic              pd_req,
    input logic              flag_sel,
    input logic [1:0]        ser_mode,
    input logic              strobe_dis,
    input logic              strobe_raw,
    input logic              cyc_movx,
    input logic              cyc_movc,
    input logic              cyc_fetch,
    input logic              strobe_out,
    input logic              strobe_drive_en
);
    logic pwr_wr, sctl_wr, ext_any;
    always_comb begin
        pwr_wr  = sfr_wr && (sfr_addr == PWR_ADDR);
        sctl_wr = sfr_wr && (sfr_addr == SCTL_ADDR);
        ext_any = cyc_movx || cyc_movc || cyc_fetch;
    end

    assert_pd_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_wr && wr_req_bits[1] && !irq_pending) |=> pd_req);

    assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_wr && wr_req_bits == 2'b01 && !irq_pending) |=> idle_req);

    assert_pd_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |-> !idle_req);

    assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |=> (!idle_req && !pd_req));

    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == PWR_ADDR) |-> (sfr_rd_data[5:4] == 2'b00));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sctl_wr && flag_sel) |=> $stable(ser_mode));

    assert_strobe_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_dis |-> (strobe_drive_en && strobe_out == strobe_raw));

    assert_strobe_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_dis && !ext_any) |-> (!strobe_drive_en && strobe_out));
endmodule

bind pwr_strobe_ctl pwr_strobe_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sfr_wr          (sfr_wr),
    .sfr_addr        (sfr_addr),
    .wr_req_bits     (sfr_wdata[1:0]),
    .sfr_rd_data     (sfr_rd_data),
    .irq_pending     (irq_pending),
    .idle_req        (idle_req),
    .pd_req          (pd_req),
    .flag_sel        (flag_sel),
    .ser_mode        (ser_mode),
    .strobe_dis      (strobe_dis),
    .strobe_raw      (strobe_raw),
    .cyc_movx        (cyc_movx),
    .cyc_movc        (cyc_movc),
    .cyc_fetch       (cyc_fetch),
    .strobe_out      (strobe_out),
    .strobe_drive_en (strobe_drive_en)
);

// File: tb/pwr_strobe_ctl_tb.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with every output 2 ns after each rising edge.
module pwr_strobe_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rd_data;
    logic       irq_pending = 1'b0;
    logic       uart_fe_set = 1'b0;
    logic       uart_ovr_set = 1'b0;
    logic [1:0] ser_mode;
    logic       ser_fe, ser_ovr, baud_dbl, pullup_ctl, idle_req, pd_req;
    logic       strobe_raw = 1'b0;
    logic       cyc_movx = 1'b0, cyc_movc = 1'b0, cyc_fetch = 1'b0;
    logic       strobe_out, strobe_drive_en;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_strobe_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rd_data(sfr_rd_data),
        .irq_pending(irq_pending), .uart_fe_set(uart_fe_set),
        .uart_ovr_set(uart_ovr_set), .ser_mode(ser_mode), .ser_fe(ser_fe),
        .ser_ovr(ser_ovr), .baud_dbl(baud_dbl), .pullup_ctl(pullup_ctl),
        .idle_req(idle_req), .pd_req(pd_req), .strobe_raw(strobe_raw),
        .cyc_movx(cyc_movx), .cyc_movc(cyc_movc), .cyc_fetch(cyc_fetch),
        .strobe_out(strobe_out), .strobe_drive_en(strobe_drive_en)
    );

    // Reference model state
    logic [7:0] m_pwr;
    logic       m_aux;
    logic [1:0] m_mode;
    logic       m_fe, m_ovr;

    always @(posedge clk) begin
        logic [7:0] p;
        if (!rst_n) begin
            m_pwr <= 8'h00; m_aux <= 1'b0; m_mode <= 2'b00;
            m_fe <= 1'b0; m_ovr <= 1'b0;
        end else begin
            p = m_pwr;
            if (sfr_wr && sfr_addr == 8'h87) p = sfr_wdata & 8'hCF;
            if (irq_pending) p[1:0] = 2'b00;
            m_pwr <= p;
            if (sfr_wr && sfr_addr == 8'h8E) m_aux <= sfr_wdata[0];
            if (sfr_wr && sfr_addr == 8'h98 && !m_pwr[6]) m_mode <= sfr_wdata[7:6];
            if (uart_fe_set) m_fe <= 1'b1;
            else if (sfr_wr && sfr_addr == 8'h98 && m_pwr[6]) m_fe <= sfr_wdata[7];
            if (uart_ovr_set) m_ovr <= 1'b1;
            else if (sfr_wr && sfr_addr == 8'h98 && m_pwr[6]) m_ovr <= sfr_wdata[6];
        end
    end

    task automatic chk(input string req, input string name,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h",
                     req, name, cycles, act, exp);
        end
    endtask

    // Compare every output shortly after each rising edge
    always @(posedge clk) begin
        logic [7:0] e_rd;
        logic       e_en;
        #2;
        cycles++;
        if (!done) begin
            case (sfr_addr)
                8'h87:   e_rd = m_pwr;
                8'h8E:   e_rd = {7'b0, m_aux};
                8'h98:   e_rd = {(m_pwr[6] ? {m_fe, m_ovr} : m_mode), 6'b0};
                default: e_rd = 8'h00;
            endcase
            e_en = !m_aux || cyc_movx || cyc_movc || cyc_fetch;
            chk("R2", "idle_req", {7'b0, idle_req}, {7'b0, m_pwr[0] & ~m_pwr[1]});
            chk("R3", "pd_req", {7'b0, pd_req}, {7'b0, m_pwr[1]});
            chk("R5", "baud_dbl", {7'b0, baud_dbl}, {7'b0, m_pwr[7]});
            chk("R5", "pullup_ctl", {7'b0, pullup_ctl}, {7'b0, m_pwr[3]});
            chk("R7", "ser_mode", {6'b0, ser_mode}, {6'b0, m_mode});
            chk("R8", "ser_fe", {7'b0, ser_fe}, {7'b0, m_fe});
            chk("R8", "ser_ovr", {7'b0, ser_ovr}, {7'b0, m_ovr});
            chk("R11", "sfr_rd_data", sfr_rd_data, e_rd);
            chk("R10", "strobe_drive_en", {7'b0, strobe_drive_en}, {7'b0, e_en});
            chk("R9", "strobe_out", {7'b0, strobe_out},
                {7'b0, e_en ? strobe_raw : 1'b1});
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wr = 1'b1; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    initial begin
        // R1: reset state, reading each owned address
        step(2);
        rst_n = 1'b1;
        sfr_addr = 8'h87; step(1);
        sfr_addr = 8'h8E; step(1);
        sfr_addr = 8'h98; step(1);

        // R2: idle request, then power-down request
        wr(8'h87, 8'h01); sfr_addr = 8'h87; step(2);
        irq_pending = 1'b1; step(1); irq_pending = 1'b0;      // R4 clear
        wr(8'h87, 8'h02); step(2);
        // R3: both bits set gives power-down only
        wr(8'h87, 8'h03); step(2);
        irq_pending = 1'b1; step(1); irq_pending = 1'b0;
        // R4: interrupt in the same cycle as the setting write
        irq_pending = 1'b1; wr(8'h87, 8'h8F); irq_pending = 1'b0; step(2);
        // R5: stored bits 7, 3, 2 read back and export
        wr(8'h87, 8'h8C); step(1);
        wr(8'h87, 8'h04); step(1);
        // R6: reserved bits stay zero
        wr(8'h87, 8'h30); step(1);
        wr(8'h87, 8'hFC); step(1);

        // R7: select clear, mode bits reached
        wr(8'h87, 8'h00);
        wr(8'h98, 8'hC0); sfr_addr = 8'h98; step(1);
        wr(8'h98, 8'h40); step(1);
        uart_fe_set = 1'b1; step(1); uart_fe_set = 1'b0;
        wr(8'h98, 8'h80); step(1);
        // R8: select set, flags reached, mode bits held
        wr(8'h87, 8'h40); sfr_addr = 8'h98; step(1);
        wr(8'h98, 8'h00); step(1);
        wr(8'h98, 8'h40); step(1);
        uart_fe_set = 1'b1; wr(8'h98, 8'h00); uart_fe_set = 1'b0; step(1);
        uart_ovr_set = 1'b1; wr(8'h98, 8'h80); uart_ovr_set = 1'b0; step(1);
        wr(8'h87, 8'h00); sfr_addr = 8'h98; step(1);

        // R11: unowned address write changes nothing
        wr(8'h55, 8'hFF); sfr_addr = 8'h55; step(1);
        sfr_addr = 8'h87; step(1);

        // R9: strobe passes every cycle while enabled
        for (int i = 0; i < 6; i++) begin
            strobe_raw = ~strobe_raw; step(1);
        end
        // R10: disabled, strobe only during external cycles
        wr(8'h8E, 8'hFF); sfr_addr = 8'h8E;
        for (int i = 0; i < 16; i++) begin
            strobe_raw = i[0];
            cyc_movx  = (i[3:1] == 3'd1);
            cyc_movc  = (i[3:1] == 3'd3);
            cyc_fetch = (i[3:1] == 3'd5);
            step(1);
        end
        cyc_movx = 1'b0; cyc_movc = 1'b0; cyc_fetch = 1'b0;
        wr(8'h8E, 8'h00); strobe_raw = 1'b0; step(1);
        strobe_raw = 1'b1; step(1);

        // R1: reset again restores everything
        wr(8'h87, 8'hCF); wr(8'h8E, 8'h01);
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        sfr_addr = 8'h87; step(1);
        sfr_addr = 8'h8E; step(1);

        done = 1'b1;
        step(1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule